// File: doc/BRIEF.md
# Manchester Command Frame Decoder

This block sits after a demodulator and rebuilds command frames from a stream of recovered chips. Each chip arrives with a one-clock strobe. Consecutive chips are paired into bits: a high-then-low pair is a one and a low-then-high pair is a zero. A pair with two equal chips is a coding violation. Pairing starts at the first strobe after reset and is never realigned.

Decoded bits feed a frame assembler. A frame is a header of `HDR_W` bits, followed by `CMD_W` command bits and then `STOP_W` trailer bits, so it is `2*(HDR_W+CMD_W+STOP_W)` chips long. The assembler hunts for the header with a sliding window. It collects the command bits and checks the trailer. It then compares the command against a preset expected code. A good frame latches the command onto the output and produces a one-clock valid pulse. A one-clock match pulse comes with it when the command equals the preset code. Violations and bad trailers each have their own one-clock error pulse. After any error or any frame, the block goes straight back to header hunting and keeps consuming chips without a gap.

Top module: `cmd_frame_decoder`

## Requirements
- R1: A chip pair 1,0 decodes to bit 1 and a pair 0,1 decodes to bit 0. Pairs are formed from strobes 1-2, 3-4 and so on, counted from reset.
- R2: A pair 0,0 or 1,1 pulses `viol_err_o` for one clock and abandons any frame in progress, so no `frame_valid_o` results from it.
- R3: The header is detected at any bit offset. It needs `HDR_W` consecutive violation-free bits, the first received bit matching bit `HDR_W-1` of `hdr_pat_i`. Bits before it are ignored.
- R4: Command bits are received most significant first. On a good frame, `cmd_o` takes the command and holds it until the next good frame.
- R5: If the trailer bits (first received = bit `STOP_W-1`) differ from `stop_pat_i`, `frame_err_o` pulses for one clock. `frame_valid_o` and `code_match_o` stay low and `cmd_o` is unchanged.
- R6: `code_match_o` pulses together with `frame_valid_o` only when the received command equals `exp_code_i`.
- R7: After an error or a completed frame, header hunting restarts at the very next bit. A frame that follows at once is decoded.
- R8: During and after reset, all outputs are zero.
- R9: `frame_valid_o`, `code_match_o`, `viol_err_o` and `frame_err_o` rise one clock after the edge that samples the strobe completing the relevant pair, and they last one clock.
- R10: Header-like bit patterns inside the command or trailer fields do not restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_i | input | 1 | Recovered chip value |
| chip_stb_i | input | 1 | Chip strobe, one clock per chip |
| hdr_pat_i | input | HDR_W | Header pattern |
| stop_pat_i | input | STOP_W | Trailer pattern |
| exp_code_i | input | CMD_W | Expected command code |
| cmd_o | output | CMD_W | Latched received command |
| frame_valid_o | output | 1 | Good frame pulse |
| code_match_o | output | 1 | Command equals expected code pulse |
| viol_err_o | output | 1 | Manchester violation pulse |
| frame_err_o | output | 1 | Bad trailer pulse |

## Verification
The valid pulse, the match pulse and the new command word all land in the same clock. The bench checks all three together against a queue-based reference model, for matching and non-matching codes. The opposite pairing is also provoked: frames whose command equals the preset code but whose trailer is wrong. For those the framing error must fire, and neither the match nor the valid pulse may fire, in that clock. Violations placed in the last trailer pair and directly before a new header test that the error pulse and the restart of hunting do not lose the following frame.

// File: rtl/cmd_frame_pkg.sv
package cmd_frame_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_STOP = 2'd2
  } asm_state_e;
endpackage

// File: rtl/manch_pair_dec.sv
module manch_pair_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_i,
  input  logic chip_stb_i,
  output logic bit_vld_o,
  output logic bit_val_o,
  output logic bit_viol_o
);
  logic half_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q     <= 1'b0;
      first_q    <= 1'b0;
      bit_vld_o  <= 1'b0;
      bit_val_o  <= 1'b0;
      bit_viol_o <= 1'b0;
    end else begin
      bit_vld_o <= 1'b0;
      if (chip_stb_i) begin
        if (!half_q) begin
          first_q <= chip_i;
          half_q  <= 1'b1;
        end else begin
          half_q     <= 1'b0;
          bit_vld_o  <= 1'b1;
          bit_val_o  <= first_q;
          bit_viol_o <= (first_q == chip_i);
        end
      end
    end
  end
endmodule

// File: rtl/hdr_hunter.sv
module hdr_hunter #(
  parameter int HDR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             clear_i,
  input  logic             bit_i,
  input  logic [HDR_W-1:0] pat_i,
  output logic             hit_o
);
  localparam int FILL_W = $clog2(HDR_W + 1);

  logic [HDR_W-1:0]  win_q, win_nxt;
  logic [FILL_W-1:0] fill_q, fill_nxt;

  always_comb begin
    win_nxt  = (win_q << 1) | HDR_W'(bit_i);
    fill_nxt = (fill_q == FILL_W'(HDR_W)) ? fill_q : fill_q + 1'b1;
    hit_o    = shift_i && (fill_nxt == FILL_W'(HDR_W)) && (win_nxt == pat_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      fill_q <= '0;
    end else if (shift_i) begin
      win_q  <= win_nxt;
      fill_q <= fill_nxt;
    end
  end
endmodule

// File: rtl/frame_assembler.sv
module frame_assembler
  import cmd_frame_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int STOP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              viol_i,
  input  logic              hit_i,
  input  logic [STOP_W-1:0] stop_pat_i,
  input  logic [CMD_W-1:0]  exp_code_i,
  output logic              hunting_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              frame_valid_o,
  output logic              code_match_o,
  output logic              viol_err_o,
  output logic              frame_err_o
);
  localparam int MAX_W = (CMD_W > STOP_W) ? CMD_W : STOP_W;
  localparam int CNT_W = $clog2(MAX_W + 1);

  asm_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-1:0]  data_q, data_nxt;
  logic [STOP_W-1:0] stop_q, stop_nxt;

  assign hunting_o = (state_q == ST_HUNT);
  assign data_nxt  = (data_q << 1) | CMD_W'(bit_i);
  assign stop_nxt  = (stop_q << 1) | STOP_W'(bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_HUNT;
      cnt_q         <= '0;
      data_q        <= '0;
      stop_q        <= '0;
      cmd_o         <= '0;
      frame_valid_o <= 1'b0;
      code_match_o  <= 1'b0;
      viol_err_o    <= 1'b0;
      frame_err_o   <= 1'b0;
    end else begin
      frame_valid_o <= 1'b0;
      code_match_o  <= 1'b0;
      viol_err_o    <= 1'b0;
      frame_err_o   <= 1'b0;
      if (bit_vld_i) begin
        if (viol_i) begin
          viol_err_o <= 1'b1;
          state_q    <= ST_HUNT;
          cnt_q      <= '0;
        end else begin
          unique case (state_q)
            ST_HUNT: begin
              cnt_q <= '0;
              if (hit_i) state_q <= ST_DATA;
            end
            ST_DATA: begin
              data_q <= data_nxt;
              if (cnt_q == CNT_W'(CMD_W - 1)) begin
                state_q <= ST_STOP;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            ST_STOP: begin
              stop_q <= stop_nxt;
              if (cnt_q == CNT_W'(STOP_W - 1)) begin
                state_q <= ST_HUNT;
                cnt_q   <= '0;
                if (stop_nxt == stop_pat_i) begin
                  cmd_o         <= data_q;
                  frame_valid_o <= 1'b1;
                  code_match_o  <= (data_q == exp_code_i);
                end else begin
                  frame_err_o <= 1'b1;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            default: state_q <= ST_HUNT;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder #(
  parameter int HDR_W  = 8,
  parameter int CMD_W  = 16,
  parameter int STOP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_i,
  input  logic              chip_stb_i,
  input  logic [HDR_W-1:0]  hdr_pat_i,
  input  logic [STOP_W-1:0] stop_pat_i,
  input  logic [CMD_W-1:0]  exp_code_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              frame_valid_o,
  output logic              code_match_o,
  output logic              viol_err_o,
  output logic              frame_err_o
);
  logic bit_vld, bit_val, bit_viol, hit, hunting;

  manch_pair_dec u_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chip_i     (chip_i),
    .chip_stb_i (chip_stb_i),
    .bit_vld_o  (bit_vld),
    .bit_val_o  (bit_val),
    .bit_viol_o (bit_viol)
  );

  hdr_hunter #(.HDR_W(HDR_W)) u_hunt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (bit_vld && !bit_viol && hunting),
    .clear_i (bit_vld && (bit_viol || hit)),
    .bit_i   (bit_val),
    .pat_i   (hdr_pat_i),
    .hit_o   (hit)
  );

  frame_assembler #(.CMD_W(CMD_W), .STOP_W(STOP_W)) u_asm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bit_vld_i     (bit_vld),
    .bit_i         (bit_val),
    .viol_i        (bit_viol),
    .hit_i         (hit),
    .stop_pat_i    (stop_pat_i),
    .exp_code_i    (exp_code_i),
    .hunting_o     (hunting),
    .cmd_o         (cmd_o),
    .frame_valid_o (frame_valid_o),
    .code_match_o  (code_match_o),
    .viol_err_o    (viol_err_o),
    .frame_err_o   (frame_err_o)
  );
endmodule

// File: rtl/cmd_frame_decoder_chk.sv
module cmd_frame_decoder_chk #(
  parameter int CMD_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CMD_W-1:0] exp_code_i,
  input logic [CMD_W-1:0] cmd_o,
  input logic             frame_valid_o,
  input logic             code_match_o,
  input logic             viol_err_o,
  input logic             frame_err_o
);
  p_valid_one_clk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);

  p_match_with_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_match_o |-> frame_valid_o);

  p_match_equal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_match_o |-> (cmd_o == exp_code_i));

  p_cmd_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != $past(cmd_o)) |-> frame_valid_o);

  p_frame_err_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !frame_valid_o && !code_match_o);

  p_viol_no_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_err_o |-> !frame_valid_o && !frame_err_o);

  p_err_one_clk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_err_o || frame_err_o) |=> !viol_err_o && !frame_err_o);
endmodule

bind cmd_frame_decoder cmd_frame_decoder_chk #(.CMD_W(CMD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .exp_code_i    (exp_code_i),
  .cmd_o         (cmd_o),
  .frame_valid_o (frame_valid_o),
  .code_match_o  (code_match_o),
  .viol_err_o    (viol_err_o),
  .frame_err_o   (frame_err_o)
);

// File: tb/tb_cmd_frame_decoder.sv
module tb_cmd_frame_decoder;
  localparam int H = 8;
  localparam int D = 16;
  localparam int S = 2;
  localparam logic [H-1:0] HDR  = 8'hB4;
  localparam logic [S-1:0] STP  = 2'b01;
  localparam logic [D-1:0] CODE = 16'hC3A5;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         chip_i = 1'b0;
  logic         chip_stb_i = 1'b0;
  logic [D-1:0] cmd_o;
  logic         frame_valid_o, code_match_o, viol_err_o, frame_err_o;

  always #10 clk_i = ~clk_i;

  cmd_frame_decoder #(.HDR_W(H), .CMD_W(D), .STOP_W(S)) dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .chip_i        (chip_i),
    .chip_stb_i    (chip_stb_i),
    .hdr_pat_i     (HDR),
    .stop_pat_i    (STP),
    .exp_code_i    (CODE),
    .cmd_o         (cmd_o),
    .frame_valid_o (frame_valid_o),
    .code_match_o  (code_match_o),
    .viol_err_o    (viol_err_o),
    .frame_err_o   (frame_err_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    running = 0;
  string scen = "R8";

  // reference model state
  bit           ph = 0;
  bit           fc = 0;
  int           mode = 0;
  bit           hist[$];
  bit           dq[$];
  bit           sq[$];
  logic [D-1:0] exp_cmd = '0;
  bit           ev_fv[int];
  bit           ev_cm[int];
  bit           ev_ve[int];
  bit           ev_fe[int];
  logic [D-1:0] ev_cmd[int];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string req, input string nm, input logic [D-1:0] act, input logic [D-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) %s cyc=%0d actual=%h expected=%h", req, scen, nm, cyc, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (running) begin
      if (ev_cmd.exists(cyc)) exp_cmd = ev_cmd[cyc];
      chk("R4", "cmd_o", cmd_o, exp_cmd);
      chk("R9", "frame_valid_o", D'(frame_valid_o), D'(ev_fv.exists(cyc)));
      chk("R6", "code_match_o", D'(code_match_o), D'(ev_cm.exists(cyc)));
      chk("R2", "viol_err_o", D'(viol_err_o), D'(ev_ve.exists(cyc)));
      chk("R5", "frame_err_o", D'(frame_err_o), D'(ev_fe.exists(cyc)));
    end
  end

  function automatic logic [D-1:0] q2v(input bit q[$]);
    logic [D-1:0] v = '0;
    foreach (q[i]) v = (v << 1) | D'(q[i]);
    return v;
  endfunction

  function automatic void model_bit(input bit b, input bit v, input int t);
    if (v) begin
      ev_ve[t] = 1;
      mode = 0;
      hist.delete();
      return;
    end
    case (mode)
      0: begin
        hist.push_back(b);
        if (hist.size() > H) void'(hist.pop_front());
        if (hist.size() == H && q2v(hist) == D'(HDR)) begin
          mode = 1;
          hist.delete();
          dq.delete();
        end
      end
      1: begin
        dq.push_back(b);
        if (dq.size() == D) begin
          mode = 2;
          sq.delete();
        end
      end
      default: begin
        sq.push_back(b);
        if (sq.size() == S) begin
          if (q2v(sq) == D'(STP)) begin
            ev_fv[t]  = 1;
            ev_cmd[t] = q2v(dq);
            if (q2v(dq) == CODE) ev_cm[t] = 1;
          end else begin
            ev_fe[t] = 1;
          end
          mode = 0;
        end
      end
    endcase
  endfunction

  // strobe sampled at edge cyc+1, outputs visible after edge cyc+2
  task automatic send_chip(input bit c);
    @(negedge clk_i);
    chip_i = c;
    chip_stb_i = 1'b1;
    if (!ph) begin
      fc = c;
      ph = 1;
    end else begin
      ph = 0;
      model_bit(fc, fc == c, cyc + 2);
    end
    @(negedge clk_i);
    chip_stb_i = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk_i);
  endtask

  // R1: bit 1 -> chips 1,0 ; bit 0 -> chips 0,1
  task automatic send_bits(input logic [D-1:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      send_chip(v[i]);
      send_chip(!v[i]);
    end
  endtask

  task automatic send_viol(input bit c);
    send_chip(c);
    send_chip(c);
  endtask

  task automatic send_frame(input logic [D-1:0] data, input logic [S-1:0] stp);
    send_bits(D'(HDR), H);
    send_bits(data, D);
    send_bits(D'(stp), S);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R8: reset values
    chk("R8", "cmd_o", cmd_o, '0);
    chk("R8", "pulses", D'({frame_valid_o, code_match_o, viol_err_o, frame_err_o}), '0);
    rst_ni = 1'b1;
    running = 1;
    repeat (2) @(negedge clk_i);

    scen = "R3 R1 R6 match after junk";
    send_bits(16'b10110, 5);
    send_frame(CODE, STP);

    scen = "R4 R6 no match";
    send_frame(16'h1234, STP);

    scen = "R5 bad trailer with matching code";
    send_frame(CODE, 2'b10);

    scen = "R7 frame right after trailer error";
    send_frame(16'h0F0F, STP);

    scen = "R2 violation mid command then R7 frame";
    send_bits(D'(HDR), H);
    send_bits(16'hAB, 8);
    send_viol(1'b1);
    send_frame(CODE, STP);

    scen = "R2 violation in last trailer pair";
    send_bits(D'(HDR), H);
    send_bits(16'h5555, D);
    send_bits(16'b0, 1);
    send_viol(1'b0);
    send_frame(16'h8001, STP);

    scen = "R10 header inside command";
    send_frame({HDR, HDR}, STP);

    scen = "R2 violation during hunt";
    send_bits(16'h0B, 5);
    send_viol(1'b0);
    send_bits(16'h4, 3);
    send_frame(16'hFFFF, STP);

    scen = "random frames";
    for (int k = 0; k < 40; k++) begin
      logic [D-1:0] d;
      d = ($urandom_range(0, 1) == 1) ? CODE : D'($urandom);
      send_bits(D'($urandom), $urandom_range(0, 6));
      if ($urandom_range(0, 5) == 0) send_viol($urandom_range(0, 1) == 1);
      send_frame(d, ($urandom_range(0, 3) == 0) ? S'($urandom) : STP);
    end

    repeat (6) @(negedge clk_i);
    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog (%s) actual=timeout expected=finish", scen);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule